// File: doc/BRIEF.md
# Configurable SPI Master Core

This block is the master end of a four-wire serial link. It shifts one word out on MOSI while it shifts one word in from MISO, in full duplex, most significant bit first. A host sets clock polarity, clock phase, a serial-clock divide factor and the index of the target slave, then pulses a start input. The core then asks a word source for data with a request/valid handshake. Each accepted word is sent while the reply is collected. Each collected reply appears on a received-data port with a one-cycle strobe.

A burst keeps the selected slave's active-low select asserted for as long as words keep arriving. When a follow-on request goes unanswered for a fixed number of system clocks, the select is released and the core returns to idle. If the first request of a burst goes unanswered, a word-source error is flagged. A start with an unusable divide factor is refused with a configuration error, and no transfer begins. Word length, slave count, divide-factor width and the request timeout are parameters.

Top module: `spi_master_core`

## Requirements
- R1: While reset is held, every select line is high, the word request, received strobe and both error outputs are low, and `sclk_o` equals `cpol_i`.
- R2: Each word taken from the source is driven on MOSI most significant bit first. The word presented on `rx_data_o` equals the bits read from MISO for that word, first bit read in the most significant position.
- R3: Whenever no select is asserted, `sclk_o` rests at the polarity level. With phase 0, data is valid before the first edge, is sampled on leading edges and changes on trailing edges. With phase 1, data changes on leading edges and is sampled on trailing edges. A leading edge is one that moves the clock away from its rest level.
- R4: The divide factor is legal when it is even and nonzero. Each serial-clock half period inside a word then lasts factor/2 system clocks.
- R5: A start with an odd or zero divide factor gives a one-cycle `cfg_err_o` pulse. No word request and no select follow.
- R6: `fifo_req_o` stays high until `fifo_valid_i` is seen high in a clock cycle. That word is loaded, and the request drops on the next cycle.
- R7: If the first request of a burst sees no valid for TMO_CYC clocks, `fifo_err_o` pulses once. The request drops after exactly TMO_CYC cycles, and no select is asserted.
- R8: Within a burst the select stays low across words. An unanswered follow-on request ends the burst after TMO_CYC clocks by releasing the select, with no error.
- R9: `rx_valid_o` pulses for exactly one cycle per transferred word, while the select is still asserted.
- R10: At most one select line is low, and it is the line indexed by the slave index latched at start.
- R11: Every word consists of exactly 2*WORD_W serial-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpol_i | input | 1 | Clock rest level |
| cpha_i | input | 1 | Clock phase select |
| div_i | input | DIV_W | System clocks per serial-clock period |
| sel_i | input | SEL_W | Index of the target slave |
| start_i | input | 1 | Begin a burst (honoured only when idle) |
| fifo_req_o | output | 1 | Request for the next word to send |
| fifo_valid_i | input | 1 | Word source answers with data |
| fifo_data_i | input | WORD_W | Word to send |
| rx_data_o | output | WORD_W | Last received word |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |
| cfg_err_o | output | 1 | Start refused: illegal divide factor |
| fifo_err_o | output | 1 | First request of a burst was not answered |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to slaves |
| miso_i | input | 1 | Serial data from slaves |
| ss_n_o | output | NUM_SLV | Active-low slave selects |

## Verification
The bound checker watches several properties on every cycle:
- at most one select is low;
- the serial clock never moves while no select is low and no request is pending;
- a select line changes only after a pending request;
- an accepted word drops the request;
- the received strobe never lasts two cycles and only appears inside a burst;
- neither error pulse coexists with a request or a select.

Bit order, the edge on which data is sampled in each of the four clock modes, the half-period length for a given divide factor, the edge count per word and the exact request timeout all depend on data and configuration. Only the bench shows these, by running a behavioural slave and word source against the core.

// File: rtl/spi_core_pkg.sv
package spi_core_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_XFER} spi_st_e;
endpackage

// File: rtl/spi_clk_gen.sv
module spi_clk_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             edge_o
);
  logic [DIV_W-1:0] cnt_q;

  assign edge_o = run_i && (cnt_q == half_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || edge_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spi_timeout.sv
module spi_timeout #(
  parameter int TMO_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int TMO_W = $clog2(TMO_CYC + 1);
  logic [TMO_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == TMO_W'(TMO_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + TMO_W'(1);
  end
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              cpha_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_q_o,
  output logic [WORD_W-1:0] rx_word_o
);
  logic [WORD_W-1:0] tx_q, rx_q;
  logic              mosi_q;

  assign rx_word_o = {rx_q[WORD_W-2:0], miso_i};
  assign rx_q_o    = rx_q;
  assign mosi_o    = mosi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      rx_q   <= '0;
      mosi_q <= 1'b0;
    end else begin
      if (load_i) begin
        // phase 0 needs the first bit on the line before the first edge
        if (!cpha_i) begin
          mosi_q <= data_i[WORD_W-1];
          tx_q   <= {data_i[WORD_W-2:0], 1'b0};
        end else begin
          mosi_q <= 1'b0;
          tx_q   <= data_i;
        end
      end else if (shift_i) begin
        mosi_q <= tx_q[WORD_W-1];
        tx_q   <= {tx_q[WORD_W-2:0], 1'b0};
      end
      if (sample_i) rx_q <= rx_word_o;
    end
  end
endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
  import spi_core_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int NUM_SLV = 4,
  parameter int DIV_W   = 4,
  parameter int TMO_CYC = 16,
  localparam int SEL_W  = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               start_i,
  output logic               fifo_req_o,
  input  logic               fifo_valid_i,
  input  logic [WORD_W-1:0]  fifo_data_i,
  output logic [WORD_W-1:0]  rx_data_o,
  output logic               rx_valid_o,
  output logic               cfg_err_o,
  output logic               fifo_err_o,
  output logic               sclk_o,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic [NUM_SLV-1:0] ss_n_o
);
  localparam int EDGE_W = $clog2(2 * WORD_W);

  spi_st_e            st_q;
  logic               cpol_q, cpha_q, burst_q, phase_q;
  logic [DIV_W-1:0]   half_q;
  logic [SEL_W-1:0]   sel_q;
  logic [EDGE_W-1:0]  edge_cnt_q;
  logic [WORD_W-1:0]  rx_data_q, rx_full, rx_word;
  logic               rx_valid_q, cfg_err_q, fifo_err_q;
  logic               sclk_edge, tmo_hit, cfg_ok, is_sample, last_edge, load;

  assign cfg_ok     = (div_i != '0) && !div_i[0];
  assign is_sample  = sclk_edge && (edge_cnt_q[0] == cpha_q);
  assign last_edge  = edge_cnt_q == EDGE_W'(2 * WORD_W - 1);
  assign load       = (st_q == ST_REQ) && fifo_valid_i;

  spi_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(st_q == ST_XFER),
    .half_i(half_q), .edge_o(sclk_edge)
  );

  spi_timeout #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(st_q == ST_REQ), .expire_o(tmo_hit)
  );

  spi_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),      .rst_ni  (rst_ni),
    .load_i  (load),       .data_i  (fifo_data_i),
    .cpha_i  (cpha_q),     .shift_i (sclk_edge && !is_sample),
    .sample_i(is_sample),  .miso_i  (miso_i),
    .mosi_o  (mosi_o),     .rx_q_o  (rx_full),
    .rx_word_o(rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cpol_q     <= 1'b0;
      cpha_q     <= 1'b0;
      half_q     <= '0;
      sel_q      <= '0;
      burst_q    <= 1'b0;
      phase_q    <= 1'b0;
      edge_cnt_q <= '0;
      rx_data_q  <= '0;
      rx_valid_q <= 1'b0;
      cfg_err_q  <= 1'b0;
      fifo_err_q <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      cfg_err_q  <= 1'b0;
      fifo_err_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (cfg_ok) begin
            cpol_q  <= cpol_i;
            cpha_q  <= cpha_i;
            half_q  <= div_i >> 1;
            sel_q   <= sel_i;
            burst_q <= 1'b0;
            st_q    <= ST_REQ;
          end else begin
            cfg_err_q <= 1'b1;
          end
        end
        ST_REQ: if (fifo_valid_i) begin
          st_q       <= ST_XFER;
          burst_q    <= 1'b1;
          phase_q    <= 1'b0;
          edge_cnt_q <= '0;
        end else if (tmo_hit) begin
          // a silent source is an error only before the first word
          fifo_err_q <= !burst_q;
          burst_q    <= 1'b0;
          st_q       <= ST_IDLE;
        end
        ST_XFER: if (sclk_edge) begin
          phase_q    <= ~phase_q;
          edge_cnt_q <= edge_cnt_q + EDGE_W'(1);
          if (last_edge) begin
            rx_data_q  <= cpha_q ? rx_word : rx_full;
            rx_valid_q <= 1'b1;
            st_q       <= ST_REQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign fifo_req_o = (st_q == ST_REQ);
  assign rx_data_o  = rx_data_q;
  assign rx_valid_o = rx_valid_q;
  assign cfg_err_o  = cfg_err_q;
  assign fifo_err_o = fifo_err_q;
  assign sclk_o     = (st_q == ST_IDLE) ? cpol_i : (cpol_q ^ phase_q);

  for (genvar g = 0; g < NUM_SLV; g++) begin : g_ss
    assign ss_n_o[g] = !(burst_q && (sel_q == SEL_W'(g)));
  end
endmodule

// File: rtl/spi_master_core_chk.sv
module spi_master_core_chk #(
  parameter int NUM_SLV = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cpol_i,
  input logic               fifo_req_o,
  input logic               fifo_valid_i,
  input logic               rx_valid_o,
  input logic               cfg_err_o,
  input logic               fifo_err_o,
  input logic               sclk_o,
  input logic [NUM_SLV-1:0] ss_n_o
);
  AST_ONE_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~ss_n_o) <= 1); // R10

  AST_SCLK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sclk_o) && (&ss_n_o) && $past(&ss_n_o) && !fifo_req_o && !$past(fifo_req_o))
      |-> !$stable(cpol_i)); // R3

  AST_SS_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ss_n_o) |-> $past(fifo_req_o)); // R8

  AST_REQ_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_req_o && fifo_valid_i) |=> !fifo_req_o); // R6

  AST_RXV_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R9

  AST_RXV_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !(&ss_n_o)); // R9

  AST_CFG_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!fifo_req_o && (&ss_n_o))); // R5

  AST_FIFO_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_err_o |-> (!fifo_req_o && (&ss_n_o))); // R7
endmodule

bind spi_master_core spi_master_core_chk #(.NUM_SLV(NUM_SLV)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpol_i      (cpol_i),
  .fifo_req_o  (fifo_req_o),
  .fifo_valid_i(fifo_valid_i),
  .rx_valid_o  (rx_valid_o),
  .cfg_err_o   (cfg_err_o),
  .fifo_err_o  (fifo_err_o),
  .sclk_o      (sclk_o),
  .ss_n_o      (ss_n_o)
);

// File: tb/spi_master_core_test.sv
module spi_master_core_test;
  localparam int W = 8, NS = 4, DW = 4, TMO = 16, SW = 2;

  logic clk_i = 1'b0;
  always #10 clk_i = ~clk_i;

  logic          rst_ni = 1'b0, cpol_i = 1'b1, cpha_i = 1'b0, start_i = 1'b0;
  logic [DW-1:0] div_i = 4'd2;
  logic [SW-1:0] sel_i = '0;
  logic          fifo_valid_i = 1'b0, miso_i = 1'b0;
  logic [W-1:0]  fifo_data_i = '0;
  logic          fifo_req_o, rx_valid_o, cfg_err_o, fifo_err_o, sclk_o, mosi_o;
  logic [W-1:0]  rx_data_o;
  logic [NS-1:0] ss_n_o;

  spi_master_core #(.WORD_W(W), .NUM_SLV(NS), .DIV_W(DW), .TMO_CYC(TMO)) uut (.*);

  int checks = 0, errors = 0, lat = 0, fifo_wait = 0, word_k = 0;
  bit done = 0, fifo_en = 1;
  bit miso_bits[$];
  logic [W-1:0] fifo_q[$], sent_q[$], exp_rx_q[$];

  // reference slave / monitor state
  logic cur_cpol = 1'b1, cur_cpha = 1'b0, prev_sclk = 1'b1;
  int   cur_div = 2, cur_sel = 0;
  bit   prev_act = 0;
  int   half_cnt, word_edges, cap_n, n_rxv, n_cfg, n_fifo, n_fall, n_rise, n_req;
  logic [W-1:0] cap_w;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_counts();
    n_rxv = 0; n_cfg = 0; n_fifo = 0; n_fall = 0; n_rise = 0; n_req = 0;
    cap_n = 0; word_edges = 0; half_cnt = 0;
  endtask

  function automatic bit pop_miso();
    return (miso_bits.size() > 0) ? miso_bits.pop_front() : 1'b0;
  endfunction

  // word source: answers a request after lat idle cycles
  always @(negedge clk_i) begin
    fifo_valid_i = 1'b0;
    if (rst_ni && fifo_req_o && fifo_en && fifo_q.size() > 0) begin
      if (fifo_wait >= lat) begin
        fifo_valid_i = 1'b1;
        fifo_data_i  = fifo_q.pop_front();
        fifo_wait    = 0;
      end else fifo_wait++;
    end else fifo_wait = 0;
  end

  // behavioural slave and per-clock comparison
  always @(negedge clk_i) begin
    if (rst_ni) begin
      automatic bit act = !(&ss_n_o);
      if (fifo_req_o) n_req++;
      if (cfg_err_o)  n_cfg++;
      if (fifo_err_o) n_fifo++;
      if (!act) chk(sclk_o == cur_cpol, "R3 rest level", sclk_o, cur_cpol);
      if (act) chk(ss_n_o == ~(NS'(1) << cur_sel), "R10 select line", ss_n_o, ~(NS'(1) << cur_sel));
      if (act && !prev_act) begin
        n_fall++; word_edges = 0; half_cnt = 0;
        if (!cur_cpha) miso_i = pop_miso();
      end
      if (!act && prev_act) n_rise++;
      if (act) begin
        half_cnt++;
        if (sclk_o != prev_sclk) begin
          automatic bit leading = (sclk_o != cur_cpol);
          if (word_edges > 0) chk(half_cnt == cur_div / 2, "R4 half period", half_cnt, cur_div / 2);
          half_cnt = 0;
          word_edges++;
          if (leading ^ cur_cpha) begin
            cap_w = {cap_w[W-2:0], mosi_o};
            cap_n++;
          end else miso_i = pop_miso();
        end
      end
      if (rx_valid_o) begin
        n_rxv++;
        chk(word_edges == 2 * W, "R11 edges per word", word_edges, 2 * W);
        chk(cap_n == W, "R3 samples per word", cap_n, W);
        if (sent_q.size() > 0) begin
          automatic logic [W-1:0] s = sent_q.pop_front();
          chk(cap_w == s, "R2 mosi word", cap_w, s);
        end
        if (exp_rx_q.size() > 0) begin
          automatic logic [W-1:0] e = exp_rx_q.pop_front();
          chk(rx_data_o == e, "R2 rx word", rx_data_o, e);
        end
        word_edges = 0; cap_n = 0;
      end
      prev_sclk = sclk_o;
      prev_act  = act;
    end
  end

  task automatic set_cfg(input logic pol, input logic pha, input int dv, input int sl);
    cpol_i = pol; cur_cpol = pol; cpha_i = pha; cur_cpha = pha;
    div_i = DW'(dv); cur_div = dv; sel_i = SW'(sl); cur_sel = sl;
    prev_sclk = pol;
  endtask

  task automatic pulse_start();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
  endtask

  task automatic run_burst(input logic pol, input logic pha, input int dv, input int sl,
                           input int n, input int lt);
    int g;
    @(negedge clk_i);
    set_cfg(pol, pha, dv, sl);
    lat = lt; fifo_en = 1;
    fifo_q.delete(); sent_q.delete(); exp_rx_q.delete(); miso_bits.delete();
    for (int i = 0; i < n; i++) begin
      automatic logic [W-1:0] tx = W'((32'h9E3779B1 * (word_k + 1)) >> 7);
      automatic logic [W-1:0] rx = W'((32'h7F4A7C15 * (word_k + 3)) >> 11);
      word_k++;
      fifo_q.push_back(tx); sent_q.push_back(tx); exp_rx_q.push_back(rx);
      for (int b = W - 1; b >= 0; b--) miso_bits.push_back(rx[b]);
    end
    clr_counts();
    pulse_start();
    g = 0;
    while (n_rise == 0 && g < 5000) begin @(negedge clk_i); g++; end
    repeat (3) @(negedge clk_i);
    chk(n_rxv == n, "R9 strobes per burst", n_rxv, n);
    chk(n_fall == 1 && n_rise == 1, "R8 single select window", n_fall + n_rise, 2);
    chk(n_fifo == 0, "R8 no error at burst end", n_fifo, 0);
    chk(n_cfg == 0, "R5 legal factor accepted", n_cfg, 0);
    chk(n_req == n * (lt + 1) + TMO, "R6 request cycles", n_req, n * (lt + 1) + TMO);
  endtask

  task automatic bad_cfg(input int dv);
    @(negedge clk_i);
    set_cfg(1'b0, 1'b0, dv, 1);
    clr_counts();
    pulse_start();
    repeat (TMO + 4) @(negedge clk_i);
    chk(n_cfg == 1, "R5 cfg error pulse", n_cfg, 1);
    chk(n_req == 0, "R5 no request", n_req, 0);
    chk(n_fall == 0, "R5 no select", n_fall, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(&ss_n_o, "R1 selects idle", ss_n_o, '1);
    chk(!fifo_req_o && !rx_valid_o, "R1 request and strobe low", fifo_req_o + rx_valid_o, 0);
    chk(!cfg_err_o && !fifo_err_o, "R1 errors low", cfg_err_o + fifo_err_o, 0);
    chk(sclk_o == cpol_i, "R1 clock rest level", sclk_o, cpol_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    run_burst(1'b0, 1'b0, 2, 0, 1, 0);
    run_burst(1'b0, 1'b1, 4, 1, 2, 1);
    run_burst(1'b1, 1'b0, 2, 2, 3, 2);
    run_burst(1'b1, 1'b1, 4, 3, 2, 0);
    run_burst(1'b0, 1'b0, 6, 1, 2, 3);
    run_burst(1'b1, 1'b1, 2, 0, 4, 1);

    bad_cfg(3);
    bad_cfg(0);

    // R7: silent source on the first request
    @(negedge clk_i);
    set_cfg(1'b1, 1'b0, 4, 2);
    fifo_en = 0;
    clr_counts();
    pulse_start();
    repeat (TMO + 6) @(negedge clk_i);
    chk(n_fifo == 1, "R7 error pulse", n_fifo, 1);
    chk(n_req == TMO, "R7 request length", n_req, TMO);
    chk(n_fall == 0, "R7 no select", n_fall, 0);
    chk(!fifo_req_o, "R7 request dropped", fifo_req_o, 0);
    fifo_en = 1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule